// File: doc/BRIEF.md
# Staged Power-Rail Sequencer

This block switches on a board's supply rails in a fixed order once an operator has made a clean press of the power button. Bring-up is split into five groups. Entering a group raises that group's regulator enable and keeps the enables of all earlier groups high. The sequencer then waits until every power-good input of the group reads high before it moves on. After the fifth group it waits for a settle interval timed by a counter. It also waits for the device's configuration-done input. It then reports ready.

While any rail is up, the block keeps watching the power-good inputs of every group it has already passed. If one of them falls, all enables drop in the same cycle and the sequencer returns to idle, where it needs a fresh press. A three-bit stage code is exported so that a status LED driver can show how far bring-up got. An aggregate all-rails-good flag is also provided. All inputs are taken as synchronous to `clk`, except the raw button, which is synchronised and debounced inside the block.

Top module: `pwr_seq_top`

## Requirements
- R1: During and after synchronous reset, `en_out` is 0, `stage_code` is 0 and `ready` is 0. In idle (code 0) no enable is ever high.
- R2: A press counts only after the synchronised button has read high for DEB_N consecutive cycles. A shorter pulse is ignored. With the button raised just before clock edge 1, the stage code reads 1 after edge DEB_N+3 and still reads 0 after edge DEB_N+2.
- R3: Stage codes are: idle 0, groups 1 to 5 as 1 to 5, settle 6, ready 7. The code only ever steps up by one, or drops to 0.
- R4: In group k, `en_out` has bits k-1..0 high and all other bits low. In settle and ready, all five bits are high.
- R5: A group advances only when all of its power-good bits are high. With the default masks these are: group 1 bit 0; group 2 bits 1 to 4; group 3 bits 5 and 6; group 4 bit 7; group 5 bits 8 to 13. The power-good bits of groups not yet reached have no effect.
- R6: The settle state lasts exactly 2^CNT_W cycles when `cfg_done` is high. Once the counter has expired, the block stays in settle until `cfg_done` is high and then moves to ready on the next edge.
- R7: `ready` is high exactly when the stage code is 7.
- R8: In any non-idle state, a low power-good bit belonging to a group already passed sends the block to idle with all enables low on the next edge.
- R9: `pg_all` is the AND of all power-good inputs, registered once.
- R10: A button press while the block is not idle has no effect on the state or the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_in | input | 1 | Raw power button, high when pressed |
| pg_in | input | PG_W | Power-good inputs, one per rail |
| cfg_done | input | 1 | Device configuration done |
| en_out | output | 5 | Regulator enables, bit k for group k+1 |
| stage_code | output | 3 | Current sequencer stage |
| ready | output | 1 | Bring-up complete |
| pg_all | output | 1 | All power-good inputs high |

## Verification
The bench builds the block with the default fourteen power-good bits, DEB_N = 4 and CNT_W = 3. With these values the debounce latency is seven cycles and settle lasts eight cycles, so both edges of each window can be hit cycle-exactly. For each group, the bench withholds each power-good bit in turn. It also drops each of the fourteen bits in turn from the ready state, so every group bit is exercised both as a gate and as a fault source.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam int unsigned NUM_GRP = 5;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_G1     = 3'd1,
    ST_G2     = 3'd2,
    ST_G3     = 3'd3,
    ST_G4     = 3'd4,
    ST_G5     = 3'd5,
    ST_SETTLE = 3'd6,
    ST_READY  = 3'd7
  } seq_st_e;
endpackage

// File: rtl/pseq_debounce.sv
module pseq_debounce #(
  parameter int unsigned DEB_N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_in,
  output logic press_o
);
  localparam int unsigned CW = $clog2(DEB_N + 1);

  logic          s1_q, s2_q, lvl_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      lvl_q   <= 1'b0;
      cnt_q   <= '0;
      press_o <= 1'b0;
    end else begin
      s1_q    <= btn_in;
      s2_q    <= s1_q;
      press_o <= 1'b0;
      if (s2_q != lvl_q) begin
        if (cnt_q == CW'(DEB_N - 1)) begin
          lvl_q   <= s2_q;
          cnt_q   <= '0;
          press_o <= s2_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R2: a press is a single-cycle event
  assert_press_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    press_o |=> !press_o);

  // R2: a press only follows a high synchronised sample
  assert_press_level_R2: assert property (@(posedge clk) disable iff (rst)
    press_o |-> lvl_q);
endmodule

// File: rtl/pseq_settle.sv
module pseq_settle #(
  parameter int unsigned CNT_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (!(&cnt_q)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = &cnt_q;

  // R6: the counter restarts whenever settle is left
  assert_settle_clear_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt_q == '0);

  // R6: once expired, the count holds while settle continues
  assert_settle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (run && done) |=> (done || cnt_q == '0));
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pseq_pkg::*;
#(
  parameter int unsigned PG_W  = 14,
  parameter int unsigned DEB_N = 4,
  parameter int unsigned CNT_W = 3,
  parameter logic [NUM_GRP*PG_W-1:0] GRP_MASK =
    {14'h3F00, 14'h0080, 14'h0060, 14'h001E, 14'h0001}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            btn_in,
  input  logic [PG_W-1:0] pg_in,
  input  logic            cfg_done,
  output logic [4:0]      en_out,
  output logic [2:0]      stage_code,
  output logic            ready,
  output logic            pg_all
);
  seq_st_e         st_q, st_d;
  logic            press, settle_done, fault;
  logic [PG_W-1:0] need, cur;
  logic [2:0]      reached;

  pseq_debounce #(.DEB_N(DEB_N)) deb_i (
    .clk(clk), .rst(rst), .btn_in(btn_in), .press_o(press)
  );

  pseq_settle #(.CNT_W(CNT_W)) settle_i (
    .clk(clk), .rst(rst), .run(st_q == ST_SETTLE), .done(settle_done)
  );

  // groups already passed, and the group currently awaited
  always_comb begin
    if (st_q == ST_IDLE)        reached = 3'd0;
    else if (st_q >= ST_SETTLE) reached = 3'(NUM_GRP);
    else                        reached = 3'(st_q) - 3'd1;
    need = '0;
    cur  = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (g < int'(reached))  need = need | GRP_MASK[g*PG_W +: PG_W];
      if (g == int'(reached)) cur  = GRP_MASK[g*PG_W +: PG_W];
    end
  end

  assign fault = (st_q != ST_IDLE) && ((pg_in & need) != need);

  always_comb begin
    st_d = st_q;
    if (fault) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:   if (press) st_d = ST_G1;
        ST_G1, ST_G2, ST_G3, ST_G4, ST_G5:
                   if ((pg_in & cur) == cur) st_d = seq_st_e'(3'(st_q) + 3'd1);
        ST_SETTLE: if (settle_done && cfg_done) st_d = ST_READY;
        ST_READY:  st_d = ST_READY;
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  function automatic logic [4:0] en_of(seq_st_e s);
    logic [5:0] t;
    int unsigned n;
    if (s == ST_IDLE)        n = 0;
    else if (s >= ST_SETTLE) n = NUM_GRP;
    else                     n = int'(s);
    t = (6'd1 << n) - 6'd1;
    return t[4:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      en_out     <= '0;
      stage_code <= '0;
      ready      <= 1'b0;
      pg_all     <= 1'b0;
    end else begin
      st_q       <= st_d;
      en_out     <= en_of(st_d);
      stage_code <= 3'(st_d);
      ready      <= (st_d == ST_READY);
      pg_all     <= &pg_in;
    end
  end

  // R1: idle keeps every rail off
  assert_idle_off_R1: assert property (@(posedge clk) disable iff (rst)
    (stage_code == 3'd0) |-> (en_out == 5'd0));

  // R3: the code only steps up by one or falls to idle
  assert_order_R3: assert property (@(posedge clk) disable iff (rst)
    (stage_code != $past(stage_code) && stage_code != 3'd0)
      |-> (stage_code == $past(stage_code) + 3'd1));

  // R7: ready only in the final stage
  assert_ready_code_R7: assert property (@(posedge clk) disable iff (rst)
    ready |-> (stage_code == 3'd7));

  // R8: a lost rail already passed forces idle on the next edge
  assert_fault_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (stage_code != 3'd0 && ((pg_in & need) != need)) |=> (stage_code == 3'd0 && en_out == 5'd0));

  // R9: aggregate flag lags the inputs by one edge
  assert_pgall_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pg_all == $past(&pg_in)));
endmodule

// File: tb/pwr_seq_top_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_top_tb_top;
  localparam int PG_W  = 14;
  localparam int DEB_N = 4;
  localparam int CNT_W = 3;
  localparam int SETTLE_LEN = 1 << CNT_W;
  localparam logic [PG_W-1:0] ALL_PG = '1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            btn_in = 1'b0;
  logic [PG_W-1:0] pg_in = '0;
  logic            cfg_done = 1'b0;
  logic [4:0]      en_out;
  logic [2:0]      stage_code;
  logic            ready, pg_all;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #10 clk = ~clk;

  pwr_seq_top #(.PG_W(PG_W), .DEB_N(DEB_N), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .btn_in(btn_in), .pg_in(pg_in), .cfg_done(cfg_done),
    .en_out(en_out), .stage_code(stage_code), .ready(ready), .pg_all(pg_all)
  );

  function automatic logic [PG_W-1:0] grp(int s);
    case (s)
      1: return 14'h0001;
      2: return 14'h001E;
      3: return 14'h0060;
      4: return 14'h0080;
      5: return 14'h3F00;
      default: return '0;
    endcase
  endfunction

  function automatic logic [PG_W-1:0] upto(int s);
    logic [PG_W-1:0] m = '0;
    for (int g = 1; g <= s; g++) m = m | grp(g);
    return m;
  endfunction

  function automatic int en_exp(int code);
    int n = (code == 0) ? 0 : ((code >= 6) ? 5 : code);
    return (1 << n) - 1;
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(string req, int code);
    check(req, "stage_code", int'(stage_code), code);
    check(req, "en_out", int'(en_out), en_exp(code));
    check(req, "ready", int'(ready), (code == 7) ? 1 : 0);
  endtask

  task automatic press_button();
    btn_in = 1'b1;
    step(DEB_N + 3);
    btn_in = 1'b0;
  endtask

  task automatic bring_up();
    pg_in = '0;
    cfg_done = 1'b1;
    step(2);
    press_button();
    for (int s = 1; s <= 5; s++) begin
      pg_in = pg_in | grp(s);
      step(1);
    end
    step(SETTLE_LEN);
  endtask

  initial begin
    step(3);
    check_state("R1", 0);
    rst = 1'b0;
    step(2);
    check_state("R1", 0);

    // R2: pulses shorter than DEB_N are ignored
    for (int len = 1; len < DEB_N; len++) begin
      btn_in = 1'b1;
      step(len);
      btn_in = 1'b0;
      step(12);
      check_state("R2", 0);
    end

    // R2 latency, R3 first step, R4 first enable
    btn_in = 1'b1;
    step(DEB_N + 2);
    check_state("R2", 0);
    step(1);
    check_state("R2", 1);
    btn_in = 1'b0;

    // R5: each group gated by every one of its bits; later bits low have no effect
    for (int s = 1; s <= 5; s++) begin
      for (int b = 0; b < PG_W; b++) begin
        if (grp(s)[b]) begin
          pg_in = upto(s) & ~(PG_W'(1) << b);
          step(3);
          check_state("R5", s);
        end
      end
      pg_in = upto(s);
      step(1);
      check_state("R4", s + 1);
    end

    // R6: settle length and waiting on cfg_done
    step(SETTLE_LEN - 1);
    check_state("R6", 6);
    step(1);
    check_state("R6", 6);
    step(5);
    check_state("R7", 6);
    cfg_done = 1'b1;
    step(1);
    check_state("R6", 7);
    check("R9", "pg_all", int'(pg_all), 1);

    // R10: press while running is ignored
    press_button();
    step(4);
    check_state("R10", 7);

    // R6: exact settle length from a fresh bring-up with cfg_done high
    pg_in = '0;
    step(1);
    check_state("R8", 0);
    cfg_done = 1'b1;
    press_button();
    for (int s = 1; s <= 5; s++) begin
      pg_in = pg_in | grp(s);
      step(1);
    end
    check_state("R6", 6);
    step(SETTLE_LEN - 1);
    check_state("R6", 6);
    step(1);
    check_state("R6", 7);

    // R8, R9: drop each rail from ready
    for (int b = 0; b < PG_W; b++) begin
      if (stage_code != 3'd7) bring_up();
      check_state("R6", 7);
      pg_in = ALL_PG & ~(PG_W'(1) << b);
      step(1);
      check_state("R8", 0);
      check("R9", "pg_all", int'(pg_all), 0);
      step(3);
      check_state("R8", 0);
    end

    // R8: fault in a middle group from an earlier group
    pg_in = '0;
    step(2);
    press_button();
    pg_in = upto(2);
    step(2);
    check_state("R5", 3);
    pg_in = upto(2) & ~PG_W'(1);
    step(1);
    check_state("R8", 0);

    done_run = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule